// File: doc/BRIEF.md
# History Buffer Recovery Unit

This block keeps register state precise in a pipeline whose functional units write the register file as soon as an instruction completes. Each decoded instruction reserves a log slot in program order. When the instruction completes, the logic that writes the new value also hands this block the destination register number and the value that register held before. Normal operand reads never pass through the block. Only recovery uses it.

When the oldest instruction finishes without a fault, its slot is released from the head of the log. On an exception, the block walks the log from the youngest slot back to the oldest. It restores one logged old value per cycle through a register-file write port, and `busy` stays high for the whole walk. For a mispredicted branch, the walk stops at the branch's own slot, so only the younger instructions are undone. A slot whose instruction never completed changed no register, so its cycle carries no write. Recovery therefore takes time in proportion to the number of slots to unwind.

Top module: `hbuf_recovery`

## Requirements
- R1: After reset the log is empty: `busy` is 0, `rf_we` is 0, `alloc_rdy` is 1 and `alloc_tag` is 0.
- R2: A granted allocation (`alloc_req` and `alloc_rdy` both high) takes slot `alloc_tag`. The next slot index is one higher, modulo DEPTH. With DEPTH live slots `alloc_rdy` is 0.
- R3: `ret_vld` releases the oldest live slot. A released slot frees room for allocation and is never restored by a later unwind.
- R4: `exc_vld` undoes every live slot, youngest first. The cycle after the request presents the youngest slot, and each later cycle presents the next older one. A completed slot gives `rf_we`=1 with its logged register in `rf_waddr` and its old value in `rf_wdata`.
- R5: `rwd_vld` with `rwd_tag` undoes only the slots younger than `rwd_tag`, in the same youngest-first order. Slot `rwd_tag` and everything older stay live.
- R6: A slot that was never completed is still stepped over during an unwind, but its cycle has `rf_we`=0.
- R7: `busy` rises the cycle after a request. It stays high for one cycle per undone slot plus one final cycle with no write, then falls. While `busy` is high, `alloc_rdy` is 0 and completions are ignored.
- R8: When `exc_vld` and `rwd_vld` arrive together, the full exception unwind is performed. New requests arriving while `busy` is high are ignored.
- R9: After an unwind, the next allocation uses the slot just after the youngest kept slot. This is the head slot after an exception and `rwd_tag`+1 after a rewind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Decode asks for a log slot |
| alloc_rdy | output | 1 | A slot can be granted this cycle |
| alloc_tag | output | IDX_W | Slot index granted to the decoding instruction |
| cmp_vld | input | 1 | An instruction completes |
| cmp_tag | input | IDX_W | Slot of the completing instruction |
| cmp_reg | input | RIDX_W | Destination register number |
| cmp_old | input | DATA_W | Value the destination held before the write |
| ret_vld | input | 1 | Oldest instruction retires without fault |
| exc_vld | input | 1 | Exception at the oldest instruction: undo all |
| rwd_vld | input | 1 | Branch mispredict: undo younger than `rwd_tag` |
| rwd_tag | input | IDX_W | Slot of the mispredicted branch |
| busy | output | 1 | Unwind in progress |
| rf_we | output | 1 | Register-file restore write enable |
| rf_waddr | output | RIDX_W | Restore register number |
| rf_wdata | output | DATA_W | Restored old value |

## Verification
The unwind is driven from a table of fill levels and completion masks. The masks include every slot done, alternate slots done, an irregular mask on a full log and no slot done. Comparing them separates a correct skip of pending slots from a write of stale data and from a walk that stops early. Partial rewinds stop either deep in the log or at the youngest slot, which tells a correct stop point from an off-by-one that undoes the branch's own slot or one slot too few. Directed cases then check:
- retirement before an exception;
- simultaneous exception and rewind requests;
- completions and requests arriving while the unwind is running;
- where the next allocation resumes after each unwind.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
   typedef enum logic {
      UW_IDLE = 1'b0,
      UW_RUN  = 1'b1
   } uw_state_e;
endpackage

// File: rtl/hbr_entry.sv
module hbr_entry #(
   parameter int RIDX_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_hit,
   input  logic              cmp_hit,
   input  logic [RIDX_W-1:0] cmp_reg,
   input  logic [DATA_W-1:0] cmp_old,
   output logic              done,
   output logic [RIDX_W-1:0] reg_id,
   output logic [DATA_W-1:0] old_val
);
   logic              done_q;
   logic [RIDX_W-1:0] reg_q;
   logic [DATA_W-1:0] old_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         reg_q  <= '0;
         old_q  <= '0;
      end else if (alloc_hit) begin
         done_q <= 1'b0;
      end else if (cmp_hit) begin
         done_q <= 1'b1;
         reg_q  <= cmp_reg;
         old_q  <= cmp_old;
      end
   end

   assign done    = done_q;
   assign reg_id  = reg_q;
   assign old_val = old_q;

   // R6
   entry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc_hit && cmp_hit));
endmodule

// File: rtl/hbr_ptrs.sv
module hbr_ptrs #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop_head,
   input  logic             pop_tail,
   output logic [IDX_W-1:0] head_idx,
   output logic [IDX_W-1:0] tail_idx,
   output logic [CNT_W-1:0] cnt,
   output logic             full,
   output logic             empty
);
   localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [IDX_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] cnt_q, cnt_nxt;

   always_comb begin
      cnt_nxt = cnt_q;
      if (push)     cnt_nxt = cnt_nxt + CNT_ONE;
      if (pop_head) cnt_nxt = cnt_nxt - CNT_ONE;
      if (pop_tail) cnt_nxt = cnt_nxt - CNT_ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push)          tail_q <= tail_q + IDX_ONE;
         else if (pop_tail) tail_q <= tail_q - IDX_ONE;
         if (pop_head)      head_q <= head_q + IDX_ONE;
         cnt_q <= cnt_nxt;
      end
   end

   assign head_idx = head_q;
   assign tail_idx = tail_q;
   assign cnt      = cnt_q;
   assign full     = (cnt_q == CNT_MAX);
   assign empty    = (cnt_q == '0);

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
   // R2
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R3
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_head || pop_tail) |-> !empty);
   // R4
   tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_tail && !push) |=> (tail_q == $past(tail_q) - IDX_ONE));
endmodule

// File: rtl/hbr_unwind.sv
module hbr_unwind #(
   parameter int DEPTH = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc_vld,
   input  logic             rwd_vld,
   input  logic [IDX_W-1:0] rwd_tag,
   input  logic [IDX_W-1:0] head_idx,
   input  logic [CNT_W-1:0] cnt,
   output logic             busy,
   output logic             pop_tail
);
   import hbr_pkg::*;

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   uw_state_e        state_q;
   logic [CNT_W-1:0] target_q;
   logic [CNT_W-1:0] keep_cnt;
   logic             start;

   // slots kept by a rewind: from head through the branch slot
   assign keep_cnt = {1'b0, rwd_tag - head_idx} + CNT_ONE;
   assign busy     = (state_q == UW_RUN);
   assign start    = !busy && (exc_vld || rwd_vld);
   assign pop_tail = busy && (cnt != target_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= UW_IDLE;
         target_q <= '0;
      end else if (start) begin
         state_q  <= UW_RUN;
         target_q <= exc_vld ? '0 : keep_cnt;
      end else if (busy && (cnt == target_q)) begin
         state_q  <= UW_IDLE;
      end
   end

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pop_tail) |=> busy);
   // R5
   target_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (target_q <= cnt));
   // R8
   exc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && exc_vld) |=> (busy && target_q == '0));
endmodule

// File: rtl/hbuf_recovery.sv
module hbuf_recovery #(
   parameter int DEPTH  = 8,
   parameter int RIDX_W = 5,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   output logic              alloc_rdy,
   output logic [IDX_W-1:0]  alloc_tag,
   input  logic              cmp_vld,
   input  logic [IDX_W-1:0]  cmp_tag,
   input  logic [RIDX_W-1:0] cmp_reg,
   input  logic [DATA_W-1:0] cmp_old,
   input  logic              ret_vld,
   input  logic              exc_vld,
   input  logic              rwd_vld,
   input  logic [IDX_W-1:0]  rwd_tag,
   output logic              busy,
   output logic              rf_we,
   output logic [RIDX_W-1:0] rf_waddr,
   output logic [DATA_W-1:0] rf_wdata
);
   localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hbuf_recovery: DEPTH must be a power of two of at least 2");
   end
   if (RIDX_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("hbuf_recovery: RIDX_W and DATA_W must be positive");
   end

   logic             accept, push, pop_head, pop_tail;
   logic             full, empty;
   logic [IDX_W-1:0] head_idx, tail_idx, rd_idx;
   logic [CNT_W-1:0] cnt;

   logic              e_done [DEPTH];
   logic [RIDX_W-1:0] e_reg  [DEPTH];
   logic [DATA_W-1:0] e_old  [DEPTH];

   assign accept    = !busy && !exc_vld && !rwd_vld;
   assign alloc_rdy = accept && !full;
   assign alloc_tag = tail_idx;
   assign push      = alloc_req && alloc_rdy;
   assign pop_head  = ret_vld && accept && !empty;
   assign rd_idx    = tail_idx - IDX_ONE;

   hbr_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .pop_head (pop_head),
      .pop_tail (pop_tail),
      .head_idx (head_idx),
      .tail_idx (tail_idx),
      .cnt      (cnt),
      .full     (full),
      .empty    (empty)
   );

   hbr_unwind #(.DEPTH(DEPTH)) u_unwind (
      .clk      (clk),
      .rst_n    (rst_n),
      .exc_vld  (exc_vld),
      .rwd_vld  (rwd_vld),
      .rwd_tag  (rwd_tag),
      .head_idx (head_idx),
      .cnt      (cnt),
      .busy     (busy),
      .pop_tail (pop_tail)
   );

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      hbr_entry #(.RIDX_W(RIDX_W), .DATA_W(DATA_W)) u_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_hit (push && (tail_idx == IDX_W'(gi))),
         .cmp_hit   (cmp_vld && accept && (cmp_tag == IDX_W'(gi))),
         .cmp_reg   (cmp_reg),
         .cmp_old   (cmp_old),
         .done      (e_done[gi]),
         .reg_id    (e_reg[gi]),
         .old_val   (e_old[gi])
      );
   end

   assign rf_we    = pop_tail && e_done[rd_idx];
   assign rf_waddr = e_reg[rd_idx];
   assign rf_wdata = e_old[rd_idx];

   // R7
   we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> busy);
   // R7
   alloc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !alloc_rdy);
   // R4
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (exc_vld || rwd_vld)) |=> busy);
   // R9
   resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $stable(tail_idx));
endmodule

// File: tb/hbuf_recovery_tb.sv
module hbuf_recovery_tb;
   localparam int DEPTH = 8;
   localparam int IDX_W = 3;
   localparam int RIDX_W = 5;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              alloc_req = 1'b0;
   logic              alloc_rdy;
   logic [IDX_W-1:0]  alloc_tag;
   logic              cmp_vld = 1'b0;
   logic [IDX_W-1:0]  cmp_tag = '0;
   logic [RIDX_W-1:0] cmp_reg = '0;
   logic [DATA_W-1:0] cmp_old = '0;
   logic              ret_vld = 1'b0;
   logic              exc_vld = 1'b0;
   logic              rwd_vld = 1'b0;
   logic [IDX_W-1:0]  rwd_tag = '0;
   logic              busy, rf_we;
   logic [RIDX_W-1:0] rf_waddr;
   logic [DATA_W-1:0] rf_wdata;

   int n_run = 0;
   int n_fail = 0;
   bit fin = 1'b0;

   always #4 clk = ~clk;

   hbuf_recovery #(.DEPTH(DEPTH), .RIDX_W(RIDX_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_rdy(alloc_rdy),
      .alloc_tag(alloc_tag), .cmp_vld(cmp_vld), .cmp_tag(cmp_tag),
      .cmp_reg(cmp_reg), .cmp_old(cmp_old), .ret_vld(ret_vld),
      .exc_vld(exc_vld), .rwd_vld(rwd_vld), .rwd_tag(rwd_tag), .busy(busy),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata));

   // fields: [15:12] fill, [11:4] done mask, [3] 1=rewind, [2:0] branch slot
   localparam logic [15:0] VEC [6] = '{
      16'h40F0, 16'h4050, 16'h63FA, 16'h8B60, 16'h51FC, 16'h3000 };

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
   endtask

   task automatic alloc_n(int n);
      for (int i = 0; i < n; i++) begin
         alloc_req = 1'b1;
         #1;
         check("R2 alloc_tag", 64'(alloc_tag), 64'(i));
         step();
         alloc_req = 1'b0;
      end
   endtask

   task automatic complete(int slot);
      cmp_vld = 1'b1;
      cmp_tag = IDX_W'(slot);
      cmp_reg = RIDX_W'(slot + 1);
      cmp_old = 32'hA000 + 32'(slot);
      step();
      cmp_vld = 1'b0;
   endtask

   // expects one cycle per slot from hi down to lo, then a final idle busy cycle
   task automatic expect_unwind(string req, int hi, int lo, logic [7:0] mask);
      for (int s = hi; s >= lo; s--) begin
         #1;
         check({req, " busy"}, 64'(busy), 64'd1);
         check({req, " R6 we"}, 64'(rf_we), 64'(mask[s]));
         if (mask[s]) begin
            check({req, " addr"}, 64'(rf_waddr), 64'(s + 1));
            check({req, " data"}, 64'(rf_wdata), 64'(32'hA000 + 32'(s)));
         end
         step();
      end
      #1;
      check({req, " R7 last busy"}, 64'(busy), 64'd1);
      check({req, " R7 last we"}, 64'(rf_we), 64'd0);
      step();
      #1;
      check({req, " R7 busy fall"}, 64'(busy), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!fin) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      #1;
      // R1 reset state
      check("R1 busy", 64'(busy), 64'd0);
      check("R1 rf_we", 64'(rf_we), 64'd0);
      check("R1 alloc_rdy", 64'(alloc_rdy), 64'd1);
      check("R1 alloc_tag", 64'(alloc_tag), 64'd0);

      // table walk: R4 R5 R6 R9
      foreach (VEC[k]) begin
         int n, stop;
         logic [7:0] mask;
         logic is_rwd;
         logic [2:0] tag;
         n = int'(VEC[k][15:12]);
         mask = VEC[k][11:4];
         is_rwd = VEC[k][3];
         tag = VEC[k][2:0];
         stop = is_rwd ? int'(tag) + 1 : 0;
         do_reset();
         alloc_n(n);
         if (n == DEPTH) begin
            #1;
            check("R2 full", 64'(alloc_rdy), 64'd0);
         end
         for (int s = n - 1; s >= 0; s--)
            if (mask[s]) complete(s);
         if (is_rwd) begin
            rwd_vld = 1'b1;
            rwd_tag = tag;
         end else begin
            exc_vld = 1'b1;
         end
         step();
         rwd_vld = 1'b0;
         exc_vld = 1'b0;
         expect_unwind(is_rwd ? "R5 rewind" : "R4 exception", n - 1, stop, mask);
         check("R9 resume tag", 64'(alloc_tag), 64'(stop));
         check("R9 alloc_rdy", 64'(alloc_rdy), 64'd1);
      end

      // R3: retire releases head, not restored later
      do_reset();
      alloc_n(3);
      complete(0); complete(1); complete(2);
      ret_vld = 1'b1;
      step();
      ret_vld = 1'b0;
      exc_vld = 1'b1;
      step();
      exc_vld = 1'b0;
      expect_unwind("R3 retire", 2, 1, 8'h07);
      check("R9 resume after retire", 64'(alloc_tag), 64'd1);

      // R3: retire on full log frees a slot
      do_reset();
      alloc_n(DEPTH);
      ret_vld = 1'b1;
      step();
      ret_vld = 1'b0;
      #1;
      check("R3 freed slot", 64'(alloc_rdy), 64'd1);
      check("R3 wrap tag", 64'(alloc_tag), 64'd0);

      // R8: exception wins over simultaneous rewind
      do_reset();
      alloc_n(4);
      complete(3); complete(1); complete(2); complete(0);
      exc_vld = 1'b1;
      rwd_vld = 1'b1;
      rwd_tag = 3'd2;
      step();
      exc_vld = 1'b0;
      rwd_vld = 1'b0;
      expect_unwind("R8 priority", 3, 0, 8'h0F);

      // R7/R8: completion and request while busy are ignored
      do_reset();
      alloc_n(3);
      exc_vld = 1'b1;
      step();
      exc_vld = 1'b0;
      #1;
      check("R7 alloc blocked", 64'(alloc_rdy), 64'd0);
      cmp_vld = 1'b1;
      cmp_tag = 3'd0;
      cmp_reg = 5'd1;
      cmp_old = 32'hA000;
      rwd_vld = 1'b1;
      rwd_tag = 3'd1;
      step();
      cmp_vld = 1'b0;
      rwd_vld = 1'b0;
      expect_unwind("R8 busy ignore", 1, 0, 8'h00);

      fin = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule